// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients. Up to four lanes are computed in parallel. Each lane keeps the middle sixteen bits of its product, bits 23 down to 8, and rounds them up when product bit 7 is set. A 3-bit mode input chooses one of seven variants. The variants differ in which byte meets which coefficient and in where each rounded result lands in the 64-bit output.

Operands arrive on two 64-bit inputs with a valid strobe. One clock later the registered result appears with its own valid strobe. Between results the output register keeps the last value it took. A datapath is expected to issue one operation per cycle through the block. Operand fetch and opcode decode stay outside the block.

Top module: `lane_mul8x16_round`

## Requirements
- R1: While rst_n is low, out_valid and result are 0.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 after a cycle with in_valid low.
- R3: Each lane forms the signed 24-bit product of a zero-extended byte and a signed 16-bit coefficient. The lane result is product bits [23:8] plus product bit [7], and the addition wraps within 16 bits, so 0xFFFF plus 1 gives 0x0000.
- R4: Mode 0 (basic) multiplies byte op_a[8i+7:8i] by coefficient op_b[16i+15:16i] for i from 0 to 3. Lane result i goes to result[16i+15:16i].
- R5: Modes 1 and 2 (shared coefficient) multiply each byte op_a[8i+7:8i], i from 0 to 3, by one coefficient. Mode 1 takes the coefficient from op_b[31:16] and mode 2 from op_b[15:0]. Lane result i goes to result[16i+15:16i].
- R6: Modes 3 and 4 (64-bit byte select) multiply one byte of each 16-bit lane of op_a by op_b[16i+15:16i]. Mode 3 uses the high byte op_a[16i+15:16i+8] and mode 4 the low byte op_a[16i+7:16i]. Lane result i goes to result[16i+15:16i].
- R7: Modes 5 and 6 (widened placement) compute only lanes 0 and 1. Mode 5 uses the high byte and mode 6 the low byte of op_a[16i+15:16i], and the coefficient is op_b[16i+15:16i]. Lane result i goes to result[32i+22:32i+7], and all other result bits are 0.
- R8: Mode 7 gives a result of all zeros.
- R9: While in_valid is low, result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid |
| mode | input | 3 | Variant select, encoded as in R4 to R8 |
| op_a | input | 64 | Byte source operand |
| op_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Rounded lane results |

## Verification
The bench aims at the rounding edge. A product of -128 has middle bits 0xFFFF and bit 7 set, so the correct result wraps to 0x0000; a design that saturates returns 0xFFFF instead, and a design that truncates returns 0xFFFF as well. It also applies a byte of 255 with coefficients of 0x8000 and 0x7FFF. A design that sign-extends the byte instead of zero-extending it returns a small value where a large positive or negative one is expected. Each mode gets operands whose bytes and coefficients are all different, so a swapped high/low byte, a swapped coefficient half or a placement shifted by the wrong amount in the widened modes gives a visible mismatch. Idle cycles between operations catch a result register that fails to hold its value.

// File: rtl/lane_mul8x16_round.sv
module lane_mul8x16_round (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  mode,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam int LANES = 4;

  logic [15:0] lane_r [LANES];
  logic [63:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0]         px;
    logic [15:0]        cf;
    logic signed [23:0] prod;

    always_comb begin
      px = 8'd0;
      cf = 16'd0;
      case (mode)
        3'd0: begin px = op_a[8*i +: 8];    cf = op_b[16*i +: 16]; end
        3'd1: begin px = op_a[8*i +: 8];    cf = op_b[31:16];      end
        3'd2: begin px = op_a[8*i +: 8];    cf = op_b[15:0];       end
        3'd3, 3'd5: begin px = op_a[16*i+8 +: 8]; cf = op_b[16*i +: 16]; end
        3'd4, 3'd6: begin px = op_a[16*i +: 8];   cf = op_b[16*i +: 16]; end
        default: begin px = 8'd0; cf = 16'd0; end
      endcase
    end

    assign prod      = $signed({1'b0, px}) * $signed(cf);
    assign lane_r[i] = prod[23:8] + {15'd0, prod[7]};
  end

  always_comb begin
    case (mode)
      3'd5, 3'd6: nxt = {9'd0, lane_r[1], 7'd0, 9'd0, lane_r[0], 7'd0};
      3'd7:       nxt = 64'd0;
      default:    nxt = {lane_r[3], lane_r[2], lane_r[1], lane_r[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 64'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_wide_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 3'd5 || mode == 3'd6)) |=>
      (result[6:0] == 7'd0 && result[31:23] == 9'd0 &&
       result[38:32] == 7'd0 && result[63:55] == 9'd0));
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd7) |=> result == 64'd0);
endmodule

// File: tb/lane_mul8x16_round_bench.sv
module lane_mul8x16_round_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [63:0] op_a = 64'd0;
  logic [63:0] op_b = 64'd0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] last_exp = 64'd0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lane_mul8x16_round u_lane_mul8x16_round (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result));

  function automatic logic [15:0] ref_lane(input logic [7:0] b, input logic [15:0] c);
    int p;
    logic [31:0] pu;
    p  = int'(b) * int'($signed(c));
    pu = p;
    return pu[23:8] + {15'd0, pu[7]};
  endfunction

  function automatic logic [63:0] ref_model(input logic [2:0] m, input logic [63:0] a,
                                            input logic [63:0] b);
    logic [63:0] r;
    r = 64'd0;
    for (int k = 0; k < 4; k++) begin
      case (m)
        3'd0: r[16*k +: 16] = ref_lane(a[8*k +: 8], b[16*k +: 16]);
        3'd1: r[16*k +: 16] = ref_lane(a[8*k +: 8], b[31:16]);
        3'd2: r[16*k +: 16] = ref_lane(a[8*k +: 8], b[15:0]);
        3'd3: r[16*k +: 16] = ref_lane(a[16*k+8 +: 8], b[16*k +: 16]);
        3'd4: r[16*k +: 16] = ref_lane(a[16*k +: 8], b[16*k +: 16]);
        3'd5: if (k < 2) r[32*k+7 +: 16] = ref_lane(a[16*k+8 +: 8], b[16*k +: 16]);
        3'd6: if (k < 2) r[32*k+7 +: 16] = ref_lane(a[16*k +: 8], b[16*k +: 16]);
        default: r = 64'd0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input string tag, input logic [2:0] m, input logic [63:0] a,
                       input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; mode = m; op_a = a; op_b = b;
    exp_q.push_back(ref_model(m, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; mode = 3'd0; op_a = 64'hDEAD_BEEF_0BAD_F00D; op_b = 64'h1234_5678_9ABC_DEF0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected valid", 64'd1, 64'd0);
      else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), result, last_exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    // R3 rounding and wrap corners in basic lanes: -128 wraps to 0, 128 rounds to 1
    issue("R3 corners", 3'd0, 64'h0000_0000_FFFF_0101, 64'h7FFF_8000_0080_FF80);
    issue("R3 R4 mixed", 3'd0, 64'h0000_0000_80C3_7F11, 64'h1234_FEDC_0F0F_A5A5);
    issue("R4 basic", 3'd0, 64'hFFFF_FFFF_0102_0304, 64'hFFFF_0001_7FFF_8001);
    issue("R5 upper coef", 3'd1, 64'h0000_0000_11FF_8002, 64'h0000_0000_C3A1_0077);
    issue("R5 lower coef", 3'd2, 64'h0000_0000_11FF_8002, 64'h0000_0000_C3A1_8077);
    idle(1);
    issue("R6 high bytes", 3'd3, 64'hA155_B266_C377_D488, 64'h8000_7FFF_1234_FF00);
    issue("R6 low bytes", 3'd4, 64'hA155_B266_C377_D488, 64'h8000_7FFF_1234_FF00);
    issue("R7 wide high", 3'd5, 64'hFFFF_FFFF_FF01_8040, 64'hFFFF_FFFF_8000_7FFF);
    issue("R7 wide low", 3'd6, 64'hFFFF_FFFF_FF01_8040, 64'hFFFF_FFFF_8000_7FFF);
    issue("R8 reserved", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
    issue("R3 R7 wrap wide", 3'd6, 64'h0000_0000_0001_0001, 64'h0000_0000_FF80_0080);
    idle(4);
    check("R2 idle no valid", {63'd0, out_valid}, 64'd0);
    check("R9 hold after idle", result, last_exp);
    issue("R4 after idle", 3'd0, 64'h0000_0000_FFFF_FFFF, 64'h0100_0200_0400_0800);
    idle(3);
    check("R9 hold final", result, last_exp);
    check("R2 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule